// File: doc/BRIEF.md
# Serial Control Word Loader

This block is a three-wire serial slave that takes configuration words from a host controller. The host shifts in a word on a data line, one bit per rising edge of a serial clock, and then raises a strobe. Each word starts with a two-bit register address and ends with a 22-bit payload. A strobe that follows a complete word copies the payload into one of four configuration registers. A strobe that follows a word of the wrong length is discarded.

All three serial lines and the mode pin are resynchronized into the system clock domain, and the serial edges are detected there. The four registers are then decoded into the live configuration:

- two synthesizer frequency words;
- an 8-bit FSK deviation;
- a PLL and data-switch field;
- a 13-bit block-enable field.

The mode pin chooses which register supplies the block-enable field. A single pin can therefore swap the configuration without a new serial transfer.

Top module: `scw_loader`

## Requirements
- R1: While reset is asserted, and after it is released with no word loaded, every decoded output reads zero.
- R2: A 24-bit word is sent address first, MSB first: bits 23:22 are the address and bits 21:0 are the payload. A word with address 0 loads its payload onto `freq0_o`.
- R3: A word with address 1 loads its payload onto `freq1_o`.
- R4: A word with address 3 drives `fsk_dev_o` with payload bits 20:13.
- R5: A word with address 2 drives `pll_cfg_o` with payload bits 20:15.
- R6: With `mode_sel` low, `blk_en_o` shows bits 12:0 of the address-3 register. With `mode_sel` high, it shows bits 12:0 of the address-2 register. Changing the pin alone switches the field.
- R7: A strobe that follows fewer than 24 serial clock rises changes no register.
- R8: A strobe that follows more than 24 serial clock rises changes no register.
- R9: Every strobe clears the bit count, so a correct word that follows a rejected one loads normally. A load changes only the register it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, address first, MSB first |
| ser_strobe | input | 1 | Rising edge commits the shifted word |
| mode_sel | input | 1 | Selects the source register of the block-enable field |
| freq0_o | output | 22 | Mode-0 frequency word (address 0) |
| freq1_o | output | 22 | Mode-1 frequency word (address 1) |
| fsk_dev_o | output | 8 | FSK deviation from the address-3 register |
| pll_cfg_o | output | 6 | PLL and data-switch field from the address-2 register |
| blk_en_o | output | 13 | Block enables, selected by `mode_sel` |

## Verification
The bench builds the block with its default parameters: a two-bit address, a 22-bit payload and a two-stage synchronizer. At these values each of the four registers can be reached, and each decoded field sits at the bit positions that the requirements fix. The serial clock runs at one eighth of the system clock. This lets the bench send words of exactly 23, 24 and 25 bits, which places the length gate on both sides of its limit. Each field is compared after every transfer and every mode change, so a load that disturbs a neighbouring register is caught.

// File: rtl/scw_pkg.sv
package scw_pkg;
   localparam int ADDR_W = 2;
   localparam int NREG   = 2 ** ADDR_W;

   typedef enum logic [ADDR_W-1:0] {
      SEL_F0  = 2'd0,
      SEL_F1  = 2'd1,
      SEL_AUX = 2'd2,
      SEL_MOD = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/scw_sync.sv
module scw_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("scw_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/scw_shifter.sv
module scw_shifter #(
   parameter int ADDR_W    = 2,
   parameter int PAYLOAD_W = 22,
   localparam int WORD_W   = ADDR_W + PAYLOAD_W,
   localparam int CNT_W    = $clog2(WORD_W + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sck_i,
   input  logic                 sdat_i,
   input  logic                 sstb_i,
   output logic                 wr_o,
   output logic [ADDR_W-1:0]    addr_o,
   output logic [PAYLOAD_W-1:0] data_o,
   output logic [CNT_W-1:0]     cnt_o,
   output logic                 stb_rise_o
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

   logic              sck_d, stb_d;
   logic              sck_rise;
   logic [WORD_W-1:0] shreg, commit_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              wr_q;

   assign sck_rise   = sck_i & ~sck_d;
   assign stb_rise_o = sstb_i & ~stb_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d    <= 1'b0;
         stb_d    <= 1'b0;
         shreg    <= '0;
         commit_q <= '0;
         cnt_q    <= '0;
         wr_q     <= 1'b0;
      end else begin
         sck_d <= sck_i;
         stb_d <= sstb_i;
         if (stb_rise_o) begin
            wr_q     <= (cnt_q == FULL);
            commit_q <= shreg;
            cnt_q    <= '0;
         end else begin
            wr_q <= 1'b0;
            if (sck_rise) begin
               shreg <= {shreg[WORD_W-2:0], sdat_i};
               if (cnt_q != OVER) cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign wr_o   = wr_q;
   assign addr_o = commit_q[WORD_W-1 -: ADDR_W];
   assign data_o = commit_q[PAYLOAD_W-1:0];
   assign cnt_o  = cnt_q;
endmodule

// File: rtl/scw_regfile.sv
module scw_regfile #(
   parameter int ADDR_W    = 2,
   parameter int PAYLOAD_W = 22,
   localparam int NREG     = 2 ** ADDR_W
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_i,
   input  logic [ADDR_W-1:0]               addr_i,
   input  logic [PAYLOAD_W-1:0]            data_i,
   output logic [NREG-1:0][PAYLOAD_W-1:0]  regs_o
);
   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         logic [PAYLOAD_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                word_q <= '0;
            else if (wr_i && addr_i == ADDR_W'(i))     word_q <= data_i;
         end
         assign regs_o[i] = word_q;
      end
   endgenerate
endmodule

// File: rtl/scw_decode.sv
module scw_decode #(
   parameter int ADDR_W    = 2,
   parameter int PAYLOAD_W = 22,
   parameter int CTL_W     = 13,
   parameter int DEV_LSB   = 13,
   parameter int DEV_W     = 8,
   parameter int PLL_LSB   = 15,
   parameter int PLL_W     = 6,
   localparam int NREG     = 2 ** ADDR_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NREG-1:0][PAYLOAD_W-1:0] regs_i,
   input  logic                           mode_i,
   output logic [PAYLOAD_W-1:0]           freq0_o,
   output logic [PAYLOAD_W-1:0]           freq1_o,
   output logic [DEV_W-1:0]               dev_o,
   output logic [PLL_W-1:0]               pll_o,
   output logic [CTL_W-1:0]               blk_o
);
   import scw_pkg::*;

   logic [PAYLOAD_W-1:0] aux_w, mod_w;
   logic                 unused_dec;

   assign aux_w      = regs_i[SEL_AUX];
   assign mod_w      = regs_i[SEL_MOD];
   assign unused_dec = ^{aux_w, mod_w};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         freq0_o <= '0;
         freq1_o <= '0;
         dev_o   <= '0;
         pll_o   <= '0;
         blk_o   <= '0;
      end else begin
         freq0_o <= regs_i[SEL_F0];
         freq1_o <= regs_i[SEL_F1];
         dev_o   <= mod_w[DEV_LSB +: DEV_W];
         pll_o   <= aux_w[PLL_LSB +: PLL_W];
         blk_o   <= mode_i ? aux_w[CTL_W-1:0] : mod_w[CTL_W-1:0];
      end
   end
endmodule

// File: rtl/scw_loader.sv
module scw_loader #(
   parameter int PAYLOAD_W   = 22,
   parameter int CTL_W       = 13,
   parameter int DEV_LSB     = 13,
   parameter int DEV_W       = 8,
   parameter int PLL_LSB     = 15,
   parameter int PLL_W       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ser_clk,
   input  logic                 ser_data,
   input  logic                 ser_strobe,
   input  logic                 mode_sel,
   output logic [PAYLOAD_W-1:0] freq0_o,
   output logic [PAYLOAD_W-1:0] freq1_o,
   output logic [DEV_W-1:0]     fsk_dev_o,
   output logic [PLL_W-1:0]     pll_cfg_o,
   output logic [CTL_W-1:0]     blk_en_o
);
   localparam int ADDR_W = scw_pkg::ADDR_W;
   localparam int NREG   = scw_pkg::NREG;
   localparam int WORD_W = ADDR_W + PAYLOAD_W;
   localparam int CNT_W  = $clog2(WORD_W + 2);

   generate
      if (DEV_LSB + DEV_W > PAYLOAD_W) begin : g_bad_dev
         $error("deviation field exceeds payload");
      end
      if (PLL_LSB + PLL_W > PAYLOAD_W) begin : g_bad_pll
         $error("PLL field exceeds payload");
      end
      if (CTL_W > PAYLOAD_W) begin : g_bad_ctl
         $error("block-enable field exceeds payload");
      end
   endgenerate

   logic [3:0]                     sync_q;
   logic                           mode_s, stb_s, dat_s, sck_s;
   logic                           wr_stb, stb_rise;
   logic [ADDR_W-1:0]              wr_addr;
   logic [PAYLOAD_W-1:0]           wr_data;
   logic [CNT_W-1:0]               bit_cnt;
   logic [NREG-1:0][PAYLOAD_W-1:0] regs;

   scw_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d_i({ser_strobe, ser_data, ser_clk, mode_sel}),
      .q_o(sync_q)
   );
   assign {stb_s, dat_s, sck_s, mode_s} = sync_q;

   scw_shifter #(.ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .sck_i(sck_s), .sdat_i(dat_s), .sstb_i(stb_s),
      .wr_o(wr_stb), .addr_o(wr_addr), .data_o(wr_data),
      .cnt_o(bit_cnt), .stb_rise_o(stb_rise)
   );

   scw_regfile #(.ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_i(wr_stb), .addr_i(wr_addr), .data_i(wr_data),
      .regs_o(regs)
   );

   scw_decode #(
      .ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W), .CTL_W(CTL_W),
      .DEV_LSB(DEV_LSB), .DEV_W(DEV_W), .PLL_LSB(PLL_LSB), .PLL_W(PLL_W)
   ) u_dec (
      .clk(clk), .rst_n(rst_n),
      .regs_i(regs), .mode_i(mode_s),
      .freq0_o(freq0_o), .freq1_o(freq1_o), .dev_o(fsk_dev_o),
      .pll_o(pll_cfg_o), .blk_o(blk_en_o)
   );
endmodule

// File: rtl/scw_loader_chk.sv
module scw_loader_chk #(
   parameter int ADDR_W    = 2,
   parameter int PAYLOAD_W = 22,
   parameter int CTL_W     = 13,
   parameter int CNT_W     = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_stb,
   input logic [ADDR_W-1:0]    wr_addr,
   input logic [PAYLOAD_W-1:0] wr_data,
   input logic [CNT_W-1:0]     bit_cnt,
   input logic                 stb_rise,
   input logic                 mode_s,
   input logic [PAYLOAD_W-1:0] freq0_o,
   input logic [CTL_W-1:0]     blk_en_o
);
   localparam int WORD_W = ADDR_W + PAYLOAD_W;

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (freq0_o == '0 && blk_en_o == '0));

   assert_freq0_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr == '0) |-> ##2 (freq0_o == $past(wr_data, 2)));

   // R7 and R8: a commit only ever follows exactly WORD_W shifted bits
   assert_len_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> ($past(bit_cnt) == CNT_W'(WORD_W)));

   assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stb_rise |=> (bit_cnt == '0));

   assert_blk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && !$past(wr_stb) && $stable(mode_s)) |=> $stable(blk_en_o));
endmodule

bind scw_loader scw_loader_chk #(
   .ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W), .CTL_W(CTL_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
   .wr_data(wr_data), .bit_cnt(bit_cnt), .stb_rise(stb_rise),
   .mode_s(mode_s), .freq0_o(freq0_o), .blk_en_o(blk_en_o)
);

// File: tb/sim_scw_loader.sv
`timescale 1ns/1ps
module sim_scw_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0, mode_sel = 1'b0;
   logic [21:0] freq0_o, freq1_o;
   logic [7:0]  fsk_dev_o;
   logic [5:0]  pll_cfg_o;
   logic [12:0] blk_en_o;

   always #5 clk = ~clk;

   scw_loader u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_strobe(ser_strobe), .mode_sel(mode_sel),
      .freq0_o(freq0_o), .freq1_o(freq1_o), .fsk_dev_o(fsk_dev_o),
      .pll_cfg_o(pll_cfg_o), .blk_en_o(blk_en_o)
   );

   typedef struct {
      logic [21:0] f0, f1;
      logic [7:0]  dev;
      logic [5:0]  pll;
      logic [12:0] blk;
      string       tag;
   } exp_t;

   exp_t   sb_q[$];
   event   chk_ev;
   int     checks = 0, errors = 0;
   bit     done = 0;
   logic [21:0] m_reg [4];
   logic        m_mode = 1'b0;

   task automatic check_field(input string req, input string tag,
                              input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s (%s): actual=%h expected=%h", req, tag, act, exp);
      end
   endtask

   task automatic push_expect(input string tag);
      exp_t e;
      e.f0  = m_reg[0];
      e.f1  = m_reg[1];
      e.dev = m_reg[3][20:13];
      e.pll = m_reg[2][20:15];
      e.blk = m_mode ? m_reg[2][12:0] : m_reg[3][12:0];
      e.tag = tag;
      sb_q.push_back(e);
      -> chk_ev;
      repeat (4) @(posedge clk);
   endtask

   // monitor: pops expectations and compares against the outputs
   initial begin
      forever begin
         @(chk_ev);
         @(negedge clk);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check_field("R2", e.tag, 32'(freq0_o),   32'(e.f0));
            check_field("R3", e.tag, 32'(freq1_o),   32'(e.f1));
            check_field("R4", e.tag, 32'(fsk_dev_o), 32'(e.dev));
            check_field("R5", e.tag, 32'(pll_cfg_o), 32'(e.pll));
            check_field("R6", e.tag, 32'(blk_en_o),  32'(e.blk));
         end
      end
   end

   // driver: shifts nbits (MSB first) of w, then strobes
   task automatic send_bits(input int nbits, input logic [31:0] w, input string tag);
      for (int i = nbits - 1; i >= 0; i--) begin
         ser_data = w[i];
         repeat (4) @(posedge clk);
         ser_clk = 1'b1;
         repeat (4) @(posedge clk);
         ser_clk = 1'b0;
      end
      repeat (4) @(posedge clk);
      ser_strobe = 1'b1;
      repeat (8) @(posedge clk);
      ser_strobe = 1'b0;
      repeat (12) @(posedge clk);
      if (nbits == 24) m_reg[w[23:22]] = w[21:0];
      push_expect(tag);
   endtask

   task automatic set_mode(input logic m, input string tag);
      mode_sel = m;
      m_mode   = m;
      repeat (12) @(posedge clk);
      push_expect(tag);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) m_reg[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if ({freq0_o, freq1_o, fsk_dev_o, pll_cfg_o, blk_en_o} !== '0) begin
         errors++;
         $display("FAIL R1 during reset: actual=%h expected=0",
                  {freq0_o, freq1_o, fsk_dev_o, pll_cfg_o, blk_en_o});
      end
      rst_n = 1'b1;
      repeat (6) @(posedge clk);
      push_expect("R1 after reset");

      send_bits(24, {8'h0, 2'd0, 22'h1B3C5D}, "R2 load addr0");
      send_bits(24, {8'h0, 2'd1, 22'h35A0F1}, "R3 load addr1, R9 addr0 kept");
      send_bits(24, {8'h0, 2'd3, 22'h2ABCDE}, "R4 load addr3, R6 mode0");
      send_bits(24, {8'h0, 2'd2, 22'h1F5A6B}, "R5 load addr2, R9 others kept");
      set_mode(1'b1, "R6 mode1 selects addr2 field");
      send_bits(23, {9'h0, 2'd0, 21'h0AAAAA}, "R7 short word ignored");
      send_bits(25, {7'h0, 1'b1, 2'd1, 22'h3FFFFF}, "R8 long word ignored");
      send_bits(24, {8'h0, 2'd3, 22'h155555}, "R9 word after rejects loads");
      set_mode(1'b0, "R6 back to mode0");
      send_bits(24, {8'h0, 2'd0, 22'h200001}, "R2 MSB and LSB of payload");
      send_bits(24, {8'h0, 2'd2, 22'h3F8000}, "R5 all PLL bits set");

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule